// File: doc/BRIEF.md
# Companion GPIO and Control Register Block

This block is a small register-mapped peripheral that sits on a simple memory bus with a byte address, a 16-bit data path and separate read and write strobes. It keeps a bank of control words (mode, card data, card control, interrupt request, interrupt mask, interrupt status), a read-only status word, a power word with a side effect on write, and a 16-line general-purpose port.

The port is built from two words: a direction word and a level word. The value driven onto the pins is the level ANDed with the direction. Each bus write to either word is followed by a per-line change strobe. The strobe marks every line whose driven value moved, and it carries the new value with it. External logic can force individual level bits from outside the bus. Those updates change the stored level but raise no strobe until the next bus write to the port.

Reads return data in the same cycle as the read strobe. Writes take effect on the clock edge. Accesses to offsets that are not mapped do nothing and pulse an error flag.

Top module: `gpio_companion`

## Requirements
- R1: After reset the status word (offset 0x08) reads 0x0002. Every other mapped offset reads 0x0000, and `gpio_drive`, `chg_strobe` and `chg_value` are 0.
- R2: The plain control words at offsets 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C each read back the last 16-bit value written to them.
- R3: A write to the power word at offset 0x0C stores the data. If bit 7 of the data is 1, bits 15 and 6 are also set, so the stored value is the data ORed with 0x8040.
- R4: The status word at offset 0x08 is read-only. A write there changes no register and raises no error.
- R5: Offset 0x20 holds the direction word and reads it back. A write to 0x24 or to 0x28 stores the data ANDed with the current direction into the level word, and a read of either offset returns the level word.
- R6: One clock edge after the edge that performs a direction or level write, `chg_strobe` is high for one cycle on exactly the lines where (level AND direction) differs from the previous `gpio_drive`. In that same cycle `chg_value` and `gpio_drive` show the new (level AND direction).
- R7: In a cycle where `pin_set_en[i]` is high, level bit i takes `pin_set_val[i]`, without direction masking. Such updates raise no strobe and leave `gpio_drive` unchanged.
- R8: When a bus write to the level word and a `pin_set_en` update fall in the same cycle, the stored level equals the bus data ANDed with direction.
- R9: A read of an unmapped offset returns 0 and a write to one changes nothing. In both cases `bus_err` is high during that strobe cycle, and it is low for mapped accesses.
- R10: `bus_rdata` is valid in the same cycle as `bus_rd`, and it is 0 when `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle as `bus_rd` |
| bus_err | output | 1 | High during an access to an unmapped offset |
| pin_set_en | input | 16 | Per-line enable for external level updates |
| pin_set_val | input | 16 | Per-line value for external level updates |
| gpio_drive | output | 16 | Driven port value (level AND direction) |
| chg_strobe | output | 16 | One-cycle per-line change marks |
| chg_value | output | 16 | New driven value that goes with the strobes |

## Verification
Two functions can fall in the same cycle: a bus write to the level word and an external per-line level update. The bench provokes this by raising `bus_wr` at offset 0x24 together with `pin_set_en` set to all ones and `pin_set_val` set to the inverse of the bus data. It then judges the result by reading the level back and by checking that the strobe pattern follows from the bus data alone. A second overlap is also exercised: an external update that lands between port writes. Its effect must appear only at the next direction or level write, as judged against a bench-side model of level, direction and previous drive.

// File: rtl/cgp_pkg.sv
// Package: shared widths, offsets and constants for the companion GPIO block.
// Assumes a 16-bit data path; offsets are byte addresses on word boundaries.
package cgp_pkg;
    localparam int DW        = 16;
    localparam int NCTL      = 8;            // words at 0x00..0x1C
    localparam int IDX_W     = $clog2(NCTL);
    localparam int IDX_STAT  = 2;            // offset 0x08
    localparam int IDX_PWR   = 3;            // offset 0x0C
    localparam int CTL_SPAN  = NCTL * 4;     // first offset past the control bank
    localparam int OFF_DIR   = 'h20;
    localparam int OFF_LVL_A = 'h24;
    localparam int OFF_LVL_B = 'h28;
    localparam int PWR_TRIG  = 7;

    typedef logic [DW-1:0] word_t;

    localparam word_t STAT_RST  = 16'h0002;
    localparam word_t PWR_FORCE = 16'h8040;
endpackage

// File: rtl/cgp_ctlregs.sv
// Module: bank of control words indexed by a word index.
// Slot IDX_STAT is a read-only constant and slot IDX_PWR applies the power
// side effect. Assumes the caller gates wr_en with a valid decode.
module cgp_ctlregs
    import cgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  word_t            wdata,
    output word_t            rdata
);
    word_t q [NCTL];

    genvar i;
    generate
        for (i = 0; i < NCTL; i++) begin : g_slot
            if (i == IDX_STAT) begin : g_stat
                // Status is a constant; writes are dropped.
                assign q[i] = STAT_RST;
            end else if (i == IDX_PWR) begin : g_pwr
                // Power word: store data, force extra bits when the trigger bit is set.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q[i] <= '0;
                    else if (wr_en && idx == IDX_W'(i))
                        q[i] <= wdata | (wdata[PWR_TRIG] ? PWR_FORCE : '0);
                end

                a_r3_power_force: assert property (@(posedge clk) disable iff (!rst_n)
                    (wr_en && idx == IDX_W'(i) && wdata[PWR_TRIG])
                    |=> ((q[i] & PWR_FORCE) == PWR_FORCE));
            end else begin : g_plain
                // Plain word: store data as written.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q[i] <= '0;
                    else if (wr_en && idx == IDX_W'(i))
                        q[i] <= wdata;
                end

                a_r2_plain_hold: assert property (@(posedge clk) disable iff (!rst_n)
                    !(wr_en && idx == IDX_W'(i)) |=> $stable(q[i]));
            end
        end
    endgenerate

    // Read mux over the bank.
    always_comb rdata = q[idx];
endmodule

// File: rtl/cgp_port.sv
// Module: direction and level words of the general-purpose port, plus
// per-line change strobes. The driven value is level AND direction. A
// direction or level write arms a compare that runs on the next edge. Assumes
// lvl_we and dir_we are never high together.
module cgp_port
    import cgp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dir_we,
    input  logic  lvl_we,
    input  word_t wdata,
    input  word_t pin_en,
    input  word_t pin_val,
    output word_t dir_q,
    output word_t lvl_q,
    output word_t drive,
    output word_t strobe,
    output word_t value
);
    logic  pend;
    word_t cur;
    word_t prev;

    assign cur   = lvl_q & dir_q;
    assign drive = prev;

    // Direction word.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (dir_we) dir_q <= wdata;
    end

    // Level word: bus write masked by direction wins over external line updates.
    always_ff @(posedge clk) begin
        if (!rst_n)      lvl_q <= '0;
        else if (lvl_we) lvl_q <= wdata & dir_q;
        else             lvl_q <= (lvl_q & ~pin_en) | (pin_val & pin_en);
    end

    // Arm the change compare after any port write.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= dir_we | lvl_we;
    end

    genvar j;
    generate
        for (j = 0; j < DW; j++) begin : g_line
            // Per-line compare, strobe and previous-drive update.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    strobe[j] <= 1'b0;
                    value[j]  <= 1'b0;
                    prev[j]   <= 1'b0;
                end else if (pend) begin
                    strobe[j] <= cur[j] ^ prev[j];
                    value[j]  <= cur[j];
                    prev[j]   <= cur[j];
                end else begin
                    strobe[j] <= 1'b0;
                end
            end
        end
    endgenerate

    a_r5_level_masked: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_we |=> ((lvl_q & ~$past(dir_q)) == '0));

    a_r6_strobe_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe != '0) |-> ((drive ^ $past(drive)) == strobe));

    a_r6_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(dir_we || lvl_we) |=> ##1 (strobe == '0));

    a_r7_drive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> $stable(drive));
endmodule

// File: rtl/gpio_companion.sv
// Module: top of the companion GPIO block. Decodes the byte offset, routes
// writes to the control bank or the port, and muxes read data
// combinationally. Assumes ADDR_W >= 7 and that bus_rd and bus_wr are
// single-cycle strobes.
module gpio_companion
    import cgp_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              bus_err,
    input  logic [15:0]       pin_set_en,
    input  logic [15:0]       pin_set_val,
    output logic [15:0]       gpio_drive,
    output logic [15:0]       chg_strobe,
    output logic [15:0]       chg_value
);
    logic  hit_ctl, hit_dir, hit_lvl, hit_any;
    word_t ctl_rd, dir_q, lvl_q;

    // Offset decode.
    always_comb begin
        hit_ctl = (bus_addr < ADDR_W'(CTL_SPAN)) && (bus_addr[1:0] == 2'b00);
        hit_dir = (bus_addr == ADDR_W'(OFF_DIR));
        hit_lvl = (bus_addr == ADDR_W'(OFF_LVL_A)) || (bus_addr == ADDR_W'(OFF_LVL_B));
        hit_any = hit_ctl | hit_dir | hit_lvl;
    end

    cgp_ctlregs u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr & hit_ctl),
        .idx   (bus_addr[IDX_W+1:2]),
        .wdata (bus_wdata),
        .rdata (ctl_rd)
    );

    cgp_port u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_we  (bus_wr & hit_dir),
        .lvl_we  (bus_wr & hit_lvl),
        .wdata   (bus_wdata),
        .pin_en  (pin_set_en),
        .pin_val (pin_set_val),
        .dir_q   (dir_q),
        .lvl_q   (lvl_q),
        .drive   (gpio_drive),
        .strobe  (chg_strobe),
        .value   (chg_value)
    );

    // Read data mux, valid in the strobe cycle.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_ctl)      bus_rdata = ctl_rd;
            else if (hit_dir) bus_rdata = dir_q;
            else if (hit_lvl) bus_rdata = lvl_q;
        end
    end

    // Error pulse for unmapped accesses.
    always_comb bus_err = (bus_rd | bus_wr) & ~hit_any;

    a_r4_status_const: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(IDX_STAT * 4)) |-> (bus_rdata == STAT_RST));

    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_err) |-> (bus_rdata == '0));

    a_r10_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_companion_tb.sv
`timescale 1ns/1ps
module gpio_companion_tb;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic          bus_err;
    logic [15:0]   pin_set_en = '0, pin_set_val = '0;
    logic [15:0]   gpio_drive, chg_strobe, chg_value;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m_ctl [8];
    logic [15:0] m_dir = '0, m_lvl = '0, m_prev = '0;

    always #2 clk = ~clk;

    gpio_companion #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .pin_set_en(pin_set_en), .pin_set_val(pin_set_val),
        .gpio_drive(gpio_drive), .chg_strobe(chg_strobe), .chg_value(chg_value)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d, output logic err);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1 err = bus_err;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [15:0] d, output logic err);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata; err = bus_err;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [15:0] exp_ctl(input int idx, input logic [15:0] v);
        if (idx == 2) return 16'h0002;
        if (idx == 3) return v | (v[7] ? 16'h8040 : 16'h0000);
        return v;
    endfunction

    // Port write followed by strobe, value and drive checks one edge later.
    task automatic port_write(input logic [AW-1:0] a, input logic [15:0] d);
        logic e;
        logic [15:0] cur, exp_s;
        if (a == 12'h020) m_dir = d;
        else              m_lvl = d & m_dir;
        cur = m_lvl & m_dir;
        exp_s = cur ^ m_prev;
        m_prev = cur;
        bus_write(a, d, e);
        check("R5 port write err", {15'b0, e}, 16'h0);
        @(posedge clk); #1;
        check("R6 chg_strobe", chg_strobe, exp_s);
        check("R6 chg_value", chg_value, cur);
        check("R6 gpio_drive", gpio_drive, cur);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x%04h expected=0x%04h", 16'h0, 16'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic e;
        for (int i = 0; i < 8; i++) m_ctl[i] = (i == 2) ? 16'h0002 : 16'h0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values of every mapped offset and the port outputs.
        for (int a = 0; a <= 'h28; a += 4) begin
            bus_read(AW'(a), d, e);
            check("R1 reset read", d, (a == 8) ? 16'h0002 : 16'h0000);
            check("R9 mapped read no err", {15'b0, e}, 16'h0);
        end
        check("R1 gpio_drive", gpio_drive, 16'h0);
        check("R1 chg_strobe", chg_strobe, 16'h0);
        check("R1 chg_value", chg_value, 16'h0);

        // R10: idle bus returns zero.
        #1 check("R10 idle rdata", bus_rdata, 16'h0);

        // R2, R4: sweep each control word with a set of patterns.
        for (int idx = 0; idx < 8; idx++) begin
            for (int k = 0; k < 16; k++) begin
                logic [15:0] v;
                v = 16'hA5C3 ^ 16'(k * 16'h1111) ^ 16'(idx << 12);
                bus_write(AW'(idx * 4), v, e);
                check((idx == 2) ? "R4 status write err" : "R2 write err", {15'b0, e}, 16'h0);
                m_ctl[idx] = exp_ctl(idx, v);
                bus_read(AW'(idx * 4), d, e);
                check((idx == 2) ? "R4 status read-only" : "R2 readback", d, m_ctl[idx]);
            end
        end

        // R3: power side effect over all low-byte values.
        for (int i = 0; i < 256; i++) begin
            logic [15:0] v;
            v = {8'(i) ^ 8'h5A, 8'(i)};
            bus_write(12'h00C, v, e);
            bus_read(12'h00C, d, e);
            check("R3 power force", d, v | (v[7] ? 16'h8040 : 16'h0000));
            m_ctl[3] = d;
        end

        // R5, R6: direction and level sweep over both level offsets.
        for (int i = 0; i < 64; i++) begin
            logic [15:0] dv, lv;
            dv = 16'(i * 16'h2F1B) ^ 16'h0F0F;
            lv = 16'(i * 16'h9E37) ^ 16'h3C5A;
            port_write(12'h020, dv);
            port_write(i[0] ? 12'h024 : 12'h028, lv);
            bus_read(12'h020, d, e);
            check("R5 dir readback", d, m_dir);
            bus_read(12'h024, d, e);
            check("R5 level via 0x24", d, m_lvl);
            bus_read(12'h028, d, e);
            check("R5 level via 0x28", d, m_lvl);
        end

        // R7: external line updates change level but not the drive.
        port_write(12'h020, 16'hFF00);
        port_write(12'h024, 16'hF0F0);
        @(negedge clk);
        pin_set_en = 16'h0FF0; pin_set_val = 16'h0AA0;
        @(negedge clk);
        pin_set_en = '0;
        m_lvl = (m_lvl & ~16'h0FF0) | (16'h0AA0 & 16'h0FF0);
        @(posedge clk); #1;
        check("R7 no strobe", chg_strobe, 16'h0);
        check("R7 drive unchanged", gpio_drive, m_prev);
        bus_read(12'h028, d, e);
        check("R7 level updated", d, m_lvl);
        check("R7 drive still unchanged", gpio_drive, m_prev);
        port_write(12'h020, 16'hFFFF);

        // R8: bus write and line update in the same cycle; bus wins.
        @(negedge clk);
        bus_addr = 12'h024; bus_wdata = 16'h1234; bus_wr = 1'b1;
        pin_set_en = 16'hFFFF; pin_set_val = 16'hEDCB;
        @(negedge clk);
        bus_wr = 1'b0; pin_set_en = '0;
        m_lvl = 16'h1234 & m_dir;
        @(posedge clk); #1;
        check("R8 strobe from bus data", chg_strobe, m_lvl ^ m_prev);
        m_prev = m_lvl & m_dir;
        bus_read(12'h024, d, e);
        check("R8 bus wins", d, 16'h1234);

        // R9: unmapped offsets.
        begin
            logic [AW-1:0] bad [6];
            bad[0] = 12'h001; bad[1] = 12'h022; bad[2] = 12'h02C;
            bad[3] = 12'h030; bad[4] = 12'h100; bad[5] = 12'hFFC;
            for (int i = 0; i < 6; i++) begin
                bus_write(bad[i], 16'hFFFF, e);
                check("R9 write err", {15'b0, e}, 16'h1);
                @(posedge clk); #1;
                check("R9 write no strobe", chg_strobe, 16'h0);
                bus_read(bad[i], d, e);
                check("R9 read zero", d, 16'h0);
                check("R9 read err", {15'b0, e}, 16'h1);
            end
        end
        for (int idx = 0; idx < 8; idx++) begin
            bus_read(AW'(idx * 4), d, e);
            check("R9 control words untouched", d, m_ctl[idx]);
        end
        bus_read(12'h020, d, e);
        check("R9 dir untouched", d, m_dir);
        bus_read(12'h028, d, e);
        check("R9 level untouched", d, m_lvl);
        check("R9 drive untouched", gpio_drive, m_prev);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule